// File: doc/BRIEF.md
# 100BASE-X Receive Framer

This block sits between the recovered serial code-group bit stream of a 100 Mb/s receiver and a nibble-wide receive interface. It watches the incoming bits for a carrier, locks code-group alignment on the two-group start-of-stream delimiter, decodes 4B/5B data groups into nibbles, and closes the frame on the two-group end-of-stream delimiter or on any coding error. A carrier that does not turn into a valid start delimiter is reported as a false carrier, so that a repeater can refuse to forward it.

Bits enter on a valid/ready stream with one bit per accepted beat. The block never applies back-pressure: `in_ready` is constant high, and a beat with `in_valid` low carries nothing and is ignored. The receive side is a plain nibble interface: `out_stb` is high for one cycle each time `nib_out`, `nib_valid` and `nib_err` take a new value, which is the equivalent of a receive-clock rising edge. Strobes come every five accepted bits and are re-phased once, at the start delimiter. A slow-mode input is the only control; it silences the error output.

Top module: `fx_rx_framer`

## Requirements
- R1: `nib_valid` rises only at the strobe produced by the bit that completes the 10-bit start delimiter 11000 10001 (first received bit first), and the first two strobes of a frame carry `nib_out` = 0101 with `nib_valid` high.
- R2: Each 5-bit data group (first received bit as the group's most significant bit) is reported one strobe after its own completion as its 4B/5B nibble, `nib_out[0]` least significant; for example 11110 gives 0000, 01001 gives 0001, 11101 gives 1111.
- R3: The group pair 01101 then 00111 ends a frame: the strobe after the last data nibble shows `nib_valid` low and `nib_err` low.
- R4: A group inside a frame that is neither one of the 16 data groups nor a correctly paired end delimiter (including idle 11111, a lone 00111, and 01101 followed by anything but 00111) produces one strobe with `nib_valid` high, `nib_err` high and `nib_out` = 0000, after which `nib_valid` stays low.
- R5: Out of a frame, a carrier is two separate runs of zero bits within the last 10 bits; if the 10-bit window three bits later is not the start delimiter, strobes show `nib_valid` low, `nib_err` high and `nib_out` = 1110 until five consecutive one bits arrive. A single zero run of any length, or two zeros ten bits apart, is not a carrier.
- R6: Outputs reset to zero and change only in the cycle where `out_stb` is high; `out_stb` fires once per five accepted bits, apart from the forced re-phase at the start delimiter.
- R7: While `slow_mode` is high at a strobe, `nib_err` is driven low at that strobe; data and valid behave as at full speed.
- R8: After reset, a frame end or an error, a start delimiter is accepted only after at least five consecutive one bits; one arriving sooner is ignored and produces no `nib_valid`.
- R9: `in_ready` is always high, and beats with `in_valid` low change nothing whatever `in_bit` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| slow_mode | input | 1 | High selects 10 Mb/s operation; error output held low |
| in_valid | input | 1 | A received bit is present on `in_bit` |
| in_bit | input | 1 | Received code-group bit, in line order |
| in_ready | output | 1 | Always high; the block never stalls the bit stream |
| out_stb | output | 1 | One-cycle pulse when the nibble outputs update |
| nib_out | output | 4 | Decoded receive nibble, bit 0 least significant |
| nib_valid | output | 1 | Frame data present on `nib_out` |
| nib_err | output | 1 | Coding error in frame, or false carrier when `nib_valid` is low |

## Verification
Directed frames of known nibbles, with and without idle gaps on the input stream, separate correct group alignment and decoding from bit-order or phase mistakes, while frames cut by idle, a lone end group, a half end delimiter or an illegal group show that each error path ends the frame with a single error strobe. Single-zero, contiguous-zero and zero pairs eight and nine ones apart tell a true carrier window from an off-by-one window, and a start delimiter sent straight after an end delimiter shows the idle requirement is enforced. Random frames with random lengths, nibbles, endings, input gaps and slow-mode settings, checked against a bench-side encoding table, then cover the mix.

// File: rtl/fx_rx_pkg.sv
package fx_rx_pkg;
  localparam int SYM_W    = 5;
  localparam int NIB_W    = 4;
  localparam int WIN_W    = 2 * SYM_W;
  localparam int CAR_TAIL = 3;

  localparam logic [WIN_W-1:0] SSD_PAIR = 10'b11000_10001;
  localparam logic [SYM_W-1:0] GRP_T    = 5'b01101;
  localparam logic [SYM_W-1:0] GRP_R    = 5'b00111;
  localparam logic [NIB_W-1:0] NIB_PRE  = 4'b0101;
  localparam logic [NIB_W-1:0] NIB_FC   = 4'b1110;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_IDLE,
    ST_CAR,
    ST_FALSE,
    ST_FRAME
  } fr_state_e;

  typedef enum logic [1:0] {
    HK_DATA,
    HK_T,
    HK_BAD
  } held_kind_e;

  typedef struct packed {
    logic             is_data;
    logic             is_t;
    logic             is_r;
    logic [NIB_W-1:0] nib;
  } grp_info_t;
endpackage

// File: rtl/fx_rx_decode.sv
module fx_rx_decode
  import fx_rx_pkg::*;
(
  input  logic [SYM_W-1:0] grp,
  output grp_info_t        info
);
  always_comb begin
    info.is_data = 1'b1;
    info.is_t    = (grp == GRP_T);
    info.is_r    = (grp == GRP_R);
    unique case (grp)
      5'b11110: info.nib = 4'h0;
      5'b01001: info.nib = 4'h1;
      5'b10100: info.nib = 4'h2;
      5'b10101: info.nib = 4'h3;
      5'b01010: info.nib = 4'h4;
      5'b01011: info.nib = 4'h5;
      5'b01110: info.nib = 4'h6;
      5'b01111: info.nib = 4'h7;
      5'b10010: info.nib = 4'h8;
      5'b10011: info.nib = 4'h9;
      5'b10110: info.nib = 4'hA;
      5'b10111: info.nib = 4'hB;
      5'b11010: info.nib = 4'hC;
      5'b11011: info.nib = 4'hD;
      5'b11100: info.nib = 4'hE;
      5'b11101: info.nib = 4'hF;
      default: begin
        info.nib     = '0;
        info.is_data = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fx_rx_window.sv
module fx_rx_window #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         bit_in,
  input  logic         fill,
  output logic [W-1:0] win_nxt,
  output logic         carrier
);
  localparam int RW = $clog2(W + 1);

  logic [W-1:0]  sr;
  logic [W:0]    pad;
  logic [RW-1:0] runs;

  assign win_nxt = {sr[W-2:0], bit_in};
  assign pad     = {1'b1, win_nxt};

  // count separate zero runs in the window seen after this bit
  always_comb begin
    runs = '0;
    for (int i = 0; i < W; i++) begin
      if (!pad[i] && pad[i+1]) runs = runs + RW'(1);
    end
  end
  assign carrier = (runs >= RW'(2));

  always_ff @(posedge clk) begin
    if (!rst_n)   sr <= '1;
    else if (adv) sr <= fill ? '1 : win_nxt;
  end

  // R8: re-entering idle search starts from a clean window
  p_fill_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && fill) |=> (&sr));
endmodule

// File: rtl/fx_rx_phase.sv
module fx_rx_phase #(
  parameter int N = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic resync,
  output logic wrap
);
  localparam int CW = $clog2(N);

  logic [CW-1:0] cnt;

  assign wrap = adv && (resync || cnt == CW'(N - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (adv) begin
      if (resync || cnt == CW'(N - 1)) cnt <= '0;
      else                             cnt <= cnt + CW'(1);
    end
  end

  // R6: group phase never leaves its range
  p_phase_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(N));
endmodule

// File: rtl/fx_rx_framer.sv
module fx_rx_framer
  import fx_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_mode,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             in_ready,
  output logic             out_stb,
  output logic [NIB_W-1:0] nib_out,
  output logic             nib_valid,
  output logic             nib_err
);
  localparam int OW = $clog2(SYM_W);
  localparam int TW = $clog2(CAR_TAIL);

  fr_state_e        st, st_n;
  held_kind_e       hk, hk_n;
  logic [NIB_W-1:0] hnib, hnib_n;
  logic [OW-1:0]    ones, ones_n;
  logic [TW-1:0]    tail, tail_n;

  logic [WIN_W-1:0] win_nxt;
  logic             carrier, jk_hit, wrap;
  logic             fill, resync, jk_event, ev_frame;
  logic [NIB_W-1:0] e_nib, s_nib;
  logic             e_dv, e_er, s_dv, s_er;
  grp_info_t        gi;

  assign in_ready = 1'b1;
  assign jk_hit   = (win_nxt == SSD_PAIR);

  fx_rx_window #(.W(WIN_W)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (in_valid),
    .bit_in  (in_bit),
    .fill    (fill),
    .win_nxt (win_nxt),
    .carrier (carrier)
  );

  fx_rx_phase #(.N(SYM_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (in_valid),
    .resync (resync),
    .wrap   (wrap)
  );

  fx_rx_decode u_decode (
    .grp  (win_nxt[SYM_W-1:0]),
    .info (gi)
  );

  always_comb begin
    st_n     = st;
    hk_n     = hk;
    hnib_n   = hnib;
    ones_n   = ones;
    tail_n   = tail;
    fill     = 1'b0;
    resync   = 1'b0;
    jk_event = 1'b0;
    ev_frame = 1'b0;
    e_nib    = '0;
    e_dv     = 1'b0;
    e_er     = 1'b0;
    if (in_valid) begin
      unique case (st)
        ST_WAIT, ST_FALSE: begin
          if (!in_bit) ones_n = '0;
          else if (ones == OW'(SYM_W - 1)) begin
            st_n   = ST_IDLE;
            fill   = 1'b1;
            ones_n = '0;
          end else ones_n = ones + OW'(1);
        end
        ST_IDLE: begin
          if (carrier) begin
            st_n   = ST_CAR;
            tail_n = '0;
          end
        end
        ST_CAR: begin
          if (tail == TW'(CAR_TAIL - 1)) begin
            if (jk_hit) begin
              st_n     = ST_FRAME;
              resync   = 1'b1;
              jk_event = 1'b1;
              hk_n     = HK_DATA;
              hnib_n   = NIB_PRE;
            end else begin
              st_n   = ST_FALSE;
              ones_n = '0;
            end
          end else tail_n = tail + TW'(1);
        end
        ST_FRAME: begin
          if (wrap) begin
            ev_frame = 1'b1;
            unique case (hk)
              HK_DATA: begin
                e_nib = hnib;
                e_dv  = 1'b1;
                if (gi.is_data) begin
                  hk_n   = HK_DATA;
                  hnib_n = gi.nib;
                end else if (gi.is_t) hk_n = HK_T;
                else                  hk_n = HK_BAD;
              end
              HK_T: begin
                if (!gi.is_r) begin
                  e_dv = 1'b1;
                  e_er = 1'b1;
                end
                st_n   = ST_WAIT;
                ones_n = '0;
              end
              default: begin
                e_dv   = 1'b1;
                e_er   = 1'b1;
                st_n   = ST_WAIT;
                ones_n = '0;
              end
            endcase
          end
        end
        default: st_n = ST_WAIT;
      endcase
    end
  end

  // value presented at each strobe
  always_comb begin
    if (jk_event) begin
      s_nib = NIB_PRE;
      s_dv  = 1'b1;
      s_er  = 1'b0;
    end else if (ev_frame) begin
      s_nib = e_nib;
      s_dv  = e_dv;
      s_er  = e_er;
    end else if (st_n == ST_FALSE) begin
      s_nib = NIB_FC;
      s_dv  = 1'b0;
      s_er  = 1'b1;
    end else begin
      s_nib = '0;
      s_dv  = 1'b0;
      s_er  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_WAIT;
      hk        <= HK_DATA;
      hnib      <= '0;
      ones      <= '0;
      tail      <= '0;
      out_stb   <= 1'b0;
      nib_out   <= '0;
      nib_valid <= 1'b0;
      nib_err   <= 1'b0;
    end else begin
      st      <= st_n;
      hk      <= hk_n;
      hnib    <= hnib_n;
      ones    <= ones_n;
      tail    <= tail_n;
      out_stb <= wrap;
      if (wrap) begin
        nib_out   <= s_nib;
        nib_valid <= s_dv;
        nib_err   <= s_er & ~slow_mode;
      end
    end
  end

  // R1: frame data only follows a recovered start delimiter
  p_dv_after_ssd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nib_valid) |-> $past(jk_event));

  // R4: an in-frame error strobe leaves the framer waiting for idle
  p_err_ends_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stb && nib_valid && nib_err) |-> (st == ST_WAIT));

  // R5: error without valid only ever carries the false-carrier code
  p_fc_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_err && !nib_valid) |-> (nib_out == NIB_FC));

  // R6: outputs hold between strobes
  p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_stb |-> $stable({nib_out, nib_valid, nib_err}));

  // R7: slow mode silences the error output
  p_slow_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stb && $past(slow_mode)) |-> !nib_err);

  // R9: never back-pressures
  p_always_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

// File: tb/test_fx_rx_framer.sv
`timescale 1ns/1ps
module test_fx_rx_framer;
  logic       clk = 1'b0;
  logic       rst_n, slow_mode, in_valid, in_bit;
  logic       in_ready, out_stb, nib_valid, nib_err;
  logic [3:0] nib_out;

  always #2 clk = ~clk;

  fx_rx_framer i_fx_rx_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_mode (slow_mode),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .in_ready  (in_ready),
    .out_stb   (out_stb),
    .nib_out   (nib_out),
    .nib_valid (nib_valid),
    .nib_err   (nib_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  int gap_max = 0;
  bit rec_on = 1'b0;
  int r_cnt = 0;
  logic [3:0] r_nib [1024];
  logic       r_dv  [1024];
  logic       r_er  [1024];
  logic [3:0] e_nib [64];

  always @(negedge clk) begin
    if (rec_on && out_stb && r_cnt < 1024) begin
      r_nib[r_cnt] = nib_out;
      r_dv[r_cnt]  = nib_valid;
      r_er[r_cnt]  = nib_err;
      r_cnt++;
    end
  end

  function automatic logic [4:0] enc5(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110;  4'h1: return 5'b01001;
      4'h2: return 5'b10100;  4'h3: return 5'b10101;
      4'h4: return 5'b01010;  4'h5: return 5'b01011;
      4'h6: return 5'b01110;  4'h7: return 5'b01111;
      4'h8: return 5'b10010;  4'h9: return 5'b10011;
      4'hA: return 5'b10110;  4'hB: return 5'b10111;
      4'hC: return 5'b11010;  4'hD: return 5'b11011;
      4'hE: return 5'b11100;  default: return 5'b11101;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    int gap;
    gap = (gap_max > 0) ? $urandom_range(0, gap_max) : 0;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid <= 1'b0;
      in_bit   <= 1'($urandom_range(0, 1));
    end
    @(negedge clk);
    in_valid <= 1'b1;
    in_bit   <= b;
  endtask

  task automatic send_grp(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) send_bit(g[i]);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic start_rec();
    r_cnt  = 0;
    rec_on = 1'b1;
  endtask

  task automatic stop_rec();
    @(negedge clk);
    in_valid <= 1'b0;
    repeat (4) @(negedge clk);
    rec_on = 1'b0;
  endtask

  // ending: 0 normal, 1 bad group at err_at, 2 end group without its pair, 3 normal plus early second frame
  task automatic send_frame(input int n, input int ending, input int err_at, input logic [4:0] bad);
    start_rec();
    send_ones(12);
    send_grp(5'b11000);
    send_grp(5'b10001);
    for (int i = 0; i < n; i++) begin
      if (ending == 1 && i == err_at) break;
      send_grp(enc5(e_nib[i]));
    end
    if (ending == 1) send_grp(bad);
    else if (ending == 2) send_grp(5'b01101);
    else begin
      send_grp(5'b01101);
      send_grp(5'b00111);
    end
    if (ending == 3) begin
      send_grp(5'b11000);
      send_grp(5'b10001);
      for (int i = 0; i < n; i++) send_grp(enc5(e_nib[i]));
      send_grp(5'b01101);
      send_grp(5'b00111);
    end
    send_ones(16);
    stop_rec();
  endtask

  // err_pos < 0: normal end; otherwise index of the error strobe after the preamble
  task automatic check_frame(input int n, input int err_pos, input string tag, output int bad);
    int f, nd, idx, f0;
    bit ok;
    f0 = n_fail;
    f  = -1;
    for (int i = 0; i < r_cnt; i++) if (r_dv[i]) begin f = i; break; end
    chk(f >= 0, "R1 frame seen", f, 0);
    if (f < 0) begin bad = 1; return; end
    ok = 1'b1;
    for (int i = 0; i < f; i++) if (r_er[i]) ok = 1'b0;
    chk(ok, "R1 no error before start", 0, 0);
    chk(r_dv[f] && r_nib[f] == 4'b0101 && r_dv[f+1] && r_nib[f+1] == 4'b0101,
        "R1 preamble nibbles", {r_nib[f], r_nib[f+1]}, 8'h55);
    nd = (err_pos < 0) ? n : err_pos;
    for (int i = 0; i < nd; i++) begin
      idx = f + 2 + i;
      chk(idx < r_cnt && r_dv[idx] && !r_er[idx] && r_nib[idx] == e_nib[i],
          "R2 data nibble", {r_dv[idx], r_er[idx], r_nib[idx]}, {2'b10, e_nib[i]});
    end
    idx = f + 2 + nd;
    if (err_pos < 0) begin
      chk(idx < r_cnt && !r_dv[idx] && !r_er[idx], "R3 end of frame",
          {r_dv[idx], r_er[idx]}, 0);
    end else begin
      chk(idx < r_cnt && r_dv[idx] && r_er[idx] == !slow_mode && r_nib[idx] == 4'h0,
          (slow_mode ? "R7 error strobe quiet" : "R4 error strobe"),
          {r_dv[idx], r_er[idx], r_nib[idx]}, {1'b1, !slow_mode, 4'h0});
      idx++;
      chk(idx < r_cnt && !r_dv[idx], "R4 valid drops after error", r_dv[idx], 0);
    end
    ok = 1'b1;
    for (int i = idx + 1; i < r_cnt; i++) if (r_dv[i] || r_er[i]) ok = 1'b0;
    chk(ok && r_cnt > idx + 1, "R8 quiet after frame", r_cnt, idx + 2);
    bad = n_fail - f0;
    if (tag != "") chk(bad == 0, tag, bad, 0);
  endtask

  // zeros: bit pattern inserted into idle, plen bits long, msb first
  task automatic send_pattern(input logic [15:0] pat, input int plen);
    start_rec();
    send_ones(12);
    for (int i = plen - 1; i >= 0; i--) send_bit(pat[i]);
    send_ones(24);
    stop_rec();
  endtask

  task automatic check_fc(input bit expect_fc, input string req);
    bit seen, dv_any, other;
    seen = 0; dv_any = 0; other = 0;
    for (int i = 0; i < r_cnt; i++) begin
      if (r_dv[i]) dv_any = 1;
      if (!r_dv[i] && r_nib[i] == 4'b1110 && r_er[i] == !slow_mode) seen = 1;
      if (r_er[i] && slow_mode) other = 1;
    end
    chk(!dv_any, req, dv_any, 0);
    chk(seen == expect_fc && !other, req, seen, expect_fc);
    chk(r_cnt > 0 && !r_dv[r_cnt-1] && !r_er[r_cnt-1] && r_nib[r_cnt-1] == 4'h0,
        "R5 idle after carrier", r_nib[r_cnt-1], 0);
  endtask

  int bad;

  initial begin
    void'($urandom(32'd20250));
    rst_n = 1'b0; slow_mode = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_stb && !nib_valid && !nib_err && nib_out == 4'h0, "R6 reset state",
        {out_stb, nib_valid, nib_err, nib_out}, 0);
    chk(in_ready, "R9 ready", in_ready, 1);

    // strobe rate over plain idle
    start_rec();
    send_ones(50);
    stop_rec();
    chk(r_cnt == 10, "R6 strobe per five bits", r_cnt, 10);

    // decode samples
    e_nib[0] = 4'h0; e_nib[1] = 4'h1; e_nib[2] = 4'hF; e_nib[3] = 4'hA;
    send_frame(4, 0, -1, 5'b0);
    check_frame(4, -1, "R2 directed frame", bad);

    // idle inside frame, lone end pair half, illegal group
    send_frame(4, 1, 2, 5'b11111);
    check_frame(4, 2, "R4 idle in frame", bad);
    send_frame(3, 1, 0, 5'b00111);
    check_frame(3, 0, "R4 lone second end group", bad);
    send_frame(4, 1, 3, 5'b11000);
    check_frame(4, 3, "R4 start group in frame", bad);
    send_frame(2, 2, -1, 5'b0);
    check_frame(2, 2, "R4 unpaired end group", bad);

    // start delimiter without idle first
    e_nib[0] = 4'h1; e_nib[1] = 4'h2; e_nib[2] = 4'h3;
    send_frame(3, 3, -1, 5'b0);
    check_frame(3, -1, "R8 early start ignored", bad);
    send_frame(3, 0, -1, 5'b0);
    check_frame(3, -1, "R8 accepted after idle", bad);

    // carrier windows
    send_pattern(16'b010, 3);
    check_fc(1'b1, "R5 split zeros");
    send_pattern(16'b000, 3);
    check_fc(1'b0, "R5 single zero run");
    send_pattern(16'b0111111110, 10);
    check_fc(1'b1, "R5 zeros nine apart");
    send_pattern(16'b01111111110, 11);
    check_fc(1'b0, "R5 zeros ten apart");

    // slow mode
    slow_mode = 1'b1;
    send_pattern(16'b010, 3);
    check_fc(1'b1, "R7 false carrier quiet");
    e_nib[0] = 4'h7; e_nib[1] = 4'hC; e_nib[2] = 4'h9;
    send_frame(3, 1, 1, 5'b00000);
    check_frame(3, 1, "R7 error quiet", bad);
    slow_mode = 1'b0;

    // gapped input stream
    gap_max = 3;
    for (int i = 0; i < 6; i++) e_nib[i] = 4'(i * 3);
    send_frame(6, 0, -1, 5'b0);
    check_frame(6, -1, "R9 gaps ignored", bad);

    // random frames
    for (int t = 0; t < 40; t++) begin
      int n, kind, ea;
      logic [4:0] bg;
      n = $urandom_range(1, 20);
      for (int i = 0; i < n; i++) e_nib[i] = 4'($urandom_range(0, 15));
      kind = $urandom_range(0, 5);
      gap_max = $urandom_range(0, 2);
      slow_mode = ($urandom_range(0, 4) == 0);
      ea = $urandom_range(0, n - 1);
      case ($urandom_range(0, 3))
        0: bg = 5'b11111;
        1: bg = 5'b00000;
        2: bg = 5'b00111;
        default: bg = 5'b10001;
      endcase
      if (kind <= 3) begin
        send_frame(n, 0, -1, bg);
        check_frame(n, -1, "", bad);
      end else if (kind == 4) begin
        send_frame(n, 1, ea, bg);
        check_frame(n, ea, "", bad);
      end else begin
        send_frame(n, 2, -1, bg);
        check_frame(n, n, "", bad);
      end
    end
    slow_mode = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule